// File: doc/BRIEF.md
# Raster Timing and Register Latch Controller

This block is the timing core of a small video display controller. A dot counter runs through a fixed number of cycles per line and a line counter through a fixed number of lines per frame. The horizontal and vertical blank flags come from these counters, together with a frame interrupt and a test pin for the host processor. The test pin goes low during the active part of each visible line and is high at all other times. When the frame reaches the first blank line, the interrupt is raised and the host can poll or take it.

A byte-wide register port sits on the host bus. It holds a control register, a read-only status register, a collision result register that the frame wrap clears, a color register, and the live line and dot-position counters. A freeze bit in the control register takes a snapshot of the line count and the dot position, and reads then return the snapshot, so the host can sample the beam position without a race. The color register is decoded into a background index and a grid index. Each index has its own brightness bit, and both are forced to zero outside the visible window.

The bus uses plain strobes. A read or write is one cycle wide, it needs no handshake and it always completes. The read data appears on the clock edge after the read strobe. There is no streaming data path, so there is no back-pressure.

Top module: `raster_timing_ctrl`

## Requirements
- R1: After reset the dot position counts 0 to 227 and wraps to 0, and the line counter steps by one at each wrap and goes from 261 back to 0, so one frame is 59736 cycles.
- R2: On lines 0 to 239, at the cycle where the dot position reaches the blank count HBLANK_DOTS (default 43), hblank falls, test_pin falls and status bit 0 becomes 1. At the start of every line, hblank and test_pin are high and status bit 0 is 0.
- R3: On entering line 240, vblank rises, status bit 3 becomes 1, frame_irq rises and test_pin stays high. frame_irq falls on entering line 241 if it is still set.
- R4: A read of the control register (address 0) clears frame_irq on that clock edge. If the read falls on the edge that enters line 240, the raise wins and frame_irq is 1.
- R5: A write to the control register stores the data byte. When data bit 1 is 1, the write captures the low 8 bits of the line count and the dot position minus HBLANK_DOTS (mod 256) in effect at that edge, and clears status bit 1. When data bit 1 is 0, status bit 1 is set.
- R6: While control bit 1 is 1, reads of address 4 (line) and address 5 (dot position) return the captured values. Otherwise they return the live low 8 bits of the line count and the live dot position minus HBLANK_DOTS, mod 256.
- R7: reg_rdata is loaded on the edge that samples reg_rd and holds the register value from that cycle. Address 0 returns the control byte and address 3 the color byte. Addresses 6 and 7 read as 0.
- R8: Writes to the status register (address 1) change nothing. Status reads as bit 3 = vblank, bit 1 = freeze-cleared flag, bit 0 = active-line flag, and all other bits 0.
- R9: On the edge that leaves line 261, the line count returns to 0, vblank falls, status bit 3 clears and the collision register (address 2, written by the host) clears. On that edge the clear wins over a host write to the collision register.
- R10: bg_index equals color bits 5:3 plus 8 when color bit 7 is set. grid_index equals color bits 2:0 plus 8 when color bit 6 is set. Both are 0 whenever hblank or vblank is high.
- R11: During reset, hblank and test_pin are 1, vblank and frame_irq are 0, and the control, color, collision and read data registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| frame_irq | output | 1 | Frame interrupt request |
| test_pin | output | 1 | Host test pin, low during active line part |
| hblank | output | 1 | Horizontal blank (also high during vertical blank) |
| vblank | output | 1 | Vertical blank |
| bg_index | output | 4 | Background color index |
| grid_index | output | 4 | Grid color index |

## Verification
The assertions assume at most one register strobe per cycle and never a read and a write together. They also assume the blank count lies strictly between 0 and the line length, so the active part of a line starts inside it. The bench keeps to this. Every access is one strobe raised for a single cycle, followed by idle gaps of random length. Random accesses cover every address, including writes to the read-only ones. Directed accesses are placed on the exact edges that enter line 240 and leave line 261.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 8;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL  = 3'd0,
    RA_STAT  = 3'd1,
    RA_COLL  = 3'd2,
    RA_COLOR = 3'd3,
    RA_LINE  = 3'd4,
    RA_HPOS  = 3'd5,
    RA_RSV6  = 3'd6,
    RA_RSV7  = 3'd7
  } reg_addr_e;

  // control bit that freezes the beam-position snapshot
  localparam int CTRL_FREEZE = 1;

  // color register fields
  localparam int COL_BG_LSB   = 3;
  localparam int COL_GRID_LSB = 0;
  localparam int COL_FLD_W    = 3;
  localparam int COL_BG_BRT   = 7;
  localparam int COL_GRID_BRT = 6;
endpackage

// File: rtl/rtc_beam.sv
module rtc_beam #(
  parameter int DOTS    = 228,
  parameter int LINES   = 262,
  parameter int HBL     = 43,
  parameter int VIS     = 240,
  parameter int HW      = 8,
  parameter int LW      = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_ack,
  output logic [HW-1:0] hc,
  output logic [LW-1:0] ly,
  output logic          hblank,
  output logic          vblank,
  output logic          irq,
  output logic          frame_wrap
);
  logic          hc_last;
  logic [LW-1:0] ly_next;
  logic          act_start;

  assign hc_last    = (hc == HW'(DOTS - 1));
  assign ly_next    = (ly == LW'(LINES - 1)) ? '0 : ly + 1'b1;
  assign frame_wrap = hc_last && (ly == LW'(LINES - 1));
  assign act_start  = (hc == HW'(HBL - 1)) && (ly < LW'(VIS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc     <= '0;
      ly     <= '0;
      hblank <= 1'b1;
      vblank <= 1'b0;
      irq    <= 1'b0;
    end else if (hc_last) begin
      hc     <= '0;
      ly     <= ly_next;
      hblank <= 1'b1;
      if (ly_next == LW'(VIS)) begin
        vblank <= 1'b1;
        irq    <= 1'b1;
      end else if (ly_next == LW'(VIS + 1) || irq_ack) begin
        irq    <= 1'b0;
      end
      if (ly_next == '0) vblank <= 1'b0;
    end else begin
      hc <= hc + 1'b1;
      if (act_start) hblank <= 1'b0;
      if (irq_ack)   irq    <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int HBL = 43,
  parameter int HW  = 8,
  parameter int LW  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic [HW-1:0]     hc,
  input  logic [LW-1:0]     ly,
  input  logic              hblank,
  input  logic              vblank,
  input  logic              frame_wrap,
  output logic [REG_DW-1:0] rdata,
  output logic [REG_DW-1:0] color,
  output logic              irq_ack,
  output logic              snap_flag
);
  logic [REG_DW-1:0] ctrl_q, coll_q, line_snap, hpos_snap;
  logic [REG_DW-1:0] line_live, hpos_live, status, rd_mux;
  logic [REG_DW-1:0] hc_ext;
  reg_addr_e         ra;

  assign ra        = reg_addr_e'(addr);
  assign hc_ext    = REG_DW'(hc);
  assign line_live = REG_DW'(ly);
  assign hpos_live = hc_ext - REG_DW'(HBL);
  assign status    = REG_DW'({vblank, 1'b0, snap_flag, ~hblank});
  assign irq_ack   = rd_en && (ra == RA_CTRL);

  always_comb begin
    case (ra)
      RA_CTRL:  rd_mux = ctrl_q;
      RA_STAT:  rd_mux = status;
      RA_COLL:  rd_mux = coll_q;
      RA_COLOR: rd_mux = color;
      RA_LINE:  rd_mux = ctrl_q[CTRL_FREEZE] ? line_snap : line_live;
      RA_HPOS:  rd_mux = ctrl_q[CTRL_FREEZE] ? hpos_snap : hpos_live;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      color     <= '0;
      coll_q    <= '0;
      line_snap <= '0;
      hpos_snap <= '0;
      snap_flag <= 1'b0;
      rdata     <= '0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      if (wr_en && ra == RA_CTRL) begin
        ctrl_q <= wdata;
        if (wdata[CTRL_FREEZE]) begin
          line_snap <= line_live;
          hpos_snap <= hpos_live;
          snap_flag <= 1'b0;
        end else begin
          snap_flag <= 1'b1;
        end
      end
      if (wr_en && ra == RA_COLOR) color <= wdata;
      if (frame_wrap)                      coll_q <= '0;
      else if (wr_en && ra == RA_COLL)     coll_q <= wdata;
    end
  end
endmodule

// File: rtl/rtc_palette.sv
module rtc_palette
  import rtc_pkg::*;
(
  input  logic [REG_DW-1:0] color,
  input  logic              hblank,
  input  logic              vblank,
  output logic [3:0]        bg_index,
  output logic [3:0]        grid_index
);
  logic visible;
  assign visible = !hblank && !vblank;

  always_comb begin
    if (visible) begin
      bg_index   = {color[COL_BG_BRT],   color[COL_BG_LSB   +: COL_FLD_W]};
      grid_index = {color[COL_GRID_BRT], color[COL_GRID_LSB +: COL_FLD_W]};
    end else begin
      bg_index   = '0;
      grid_index = '0;
    end
  end
endmodule

// File: rtl/raster_timing_ctrl.sv
module raster_timing_ctrl
  import rtc_pkg::*;
#(
  parameter int DOTS_PER_LINE   = 228,
  parameter int LINES_PER_FRAME = 262,
  parameter int HBLANK_DOTS     = 43,
  parameter int VISIBLE_LINES   = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              frame_irq,
  output logic              test_pin,
  output logic              hblank,
  output logic              vblank,
  output logic [3:0]        bg_index,
  output logic [3:0]        grid_index
);
  localparam int HW = $clog2(DOTS_PER_LINE);
  localparam int LW = $clog2(LINES_PER_FRAME);

  logic [HW-1:0]     beam_hc;
  logic [LW-1:0]     beam_ly;
  logic              frame_wrap, irq_ack, snap_flag;
  logic [REG_DW-1:0] color;

  rtc_beam #(
    .DOTS(DOTS_PER_LINE), .LINES(LINES_PER_FRAME), .HBL(HBLANK_DOTS),
    .VIS(VISIBLE_LINES), .HW(HW), .LW(LW)
  ) u_beam (
    .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack),
    .hc(beam_hc), .ly(beam_ly), .hblank(hblank), .vblank(vblank),
    .irq(frame_irq), .frame_wrap(frame_wrap)
  );

  rtc_regs #(.HBL(HBLANK_DOTS), .HW(HW), .LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_en(reg_rd), .wr_en(reg_wr),
    .addr(reg_addr), .wdata(reg_wdata), .hc(beam_hc), .ly(beam_ly),
    .hblank(hblank), .vblank(vblank), .frame_wrap(frame_wrap),
    .rdata(reg_rdata), .color(color), .irq_ack(irq_ack), .snap_flag(snap_flag)
  );

  rtc_palette u_pal (
    .color(color), .hblank(hblank), .vblank(vblank),
    .bg_index(bg_index), .grid_index(grid_index)
  );

  // test pin is high whenever the beam is outside the active part of a line
  assign test_pin = hblank;
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker #(
  parameter int DOTS = 228,
  parameter int LINES = 262,
  parameter int HBL = 43,
  parameter int VIS = 240,
  parameter int HW = 8,
  parameter int LW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic [HW-1:0] hc,
  input logic [LW-1:0] ly,
  input logic          hblank,
  input logic          vblank,
  input logic          frame_irq,
  input logic          snap_flag,
  input logic [3:0]    bg_index,
  input logic [3:0]    grid_index
);
  AST_DOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hc) < DOTS && int'(ly) < LINES);                             // R1
  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hc) == DOTS - 1 |=> hc == '0);                               // R1
  AST_ACTIVE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(hc) == HBL && int'(ly) < VIS) |-> !hblank);                 // R2
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_irq) |-> (int'(ly) == VIS && hc == '0 && vblank));    // R3
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ly) == VIS + 1) |-> !frame_irq);                            // R3
  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd0 && !(int'(ly) == VIS - 1 && int'(hc) == DOTS - 1))
      |=> !frame_irq);                                                // R4
  AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd1) |=> $stable(snap_flag));             // R8
  AST_FRAME_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ly == '0) |-> !vblank);                                          // R9
  AST_PIX_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (hblank || vblank) |-> (bg_index == 4'd0 && grid_index == 4'd0)); // R10
endmodule

bind raster_timing_ctrl rtc_checker #(
  .DOTS(DOTS_PER_LINE), .LINES(LINES_PER_FRAME), .HBL(HBLANK_DOTS),
  .VIS(VISIBLE_LINES), .HW(HW), .LW(LW)
) u_rtc_checker (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .hc(beam_hc), .ly(beam_ly), .hblank(hblank),
  .vblank(vblank), .frame_irq(frame_irq), .snap_flag(snap_flag),
  .bg_index(bg_index), .grid_index(grid_index)
);

// File: tb/raster_timing_ctrl_bench.sv
module raster_timing_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DOTS = 228;
  localparam int LINES = 262;
  localparam int HBL = 43;
  localparam int VIS = 240;
  localparam int FRM = DOTS * LINES;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_rd = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       frame_irq, test_pin, hblank, vblank;
  logic [3:0] bg_index, grid_index;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  // bench model of host-visible state
  int ctrl_m = 0, color_m = 0, coll_m = 0, coll_frame = -1;
  int line_snap_m = 0, hpos_snap_m = 0, snap_m = 0, ack_frame = -1;

  raster_timing_ctrl u_raster_timing_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frame_irq(frame_irq), .test_pin(test_pin), .hblank(hblank),
    .vblank(vblank), .bg_index(bg_index), .grid_index(grid_index)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  function automatic int e_hc(int c); return c % DOTS; endfunction
  function automatic int e_ly(int c); return (c / DOTS) % LINES; endfunction
  function automatic bit e_vis(int c);
    return e_ly(c) < VIS && e_hc(c) >= HBL;
  endfunction
  function automatic int e_hpos(int c); return (e_hc(c) - HBL) & 255; endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    int c = cyc;
    bit v = e_vis(c);
    int bg = v ? (((color_m >> 3) & 7) + ((color_m >> 7) & 1) * 8) : 0;
    int gr = v ? ((color_m & 7) + ((color_m >> 6) & 1) * 8) : 0;
    bit irq_e = (e_ly(c) == VIS) && (ack_frame != c / FRM);
    chk(hblank == !v, "R2", "hblank", int'(hblank), int'(!v));
    chk(test_pin == !v, "R2", "test_pin", int'(test_pin), int'(!v));
    chk(vblank == (e_ly(c) >= VIS), "R3", "vblank", int'(vblank), int'(e_ly(c) >= VIS));
    chk(frame_irq == irq_e, "R3/R4", "frame_irq", int'(frame_irq), int'(irq_e));
    chk(int'(bg_index) == bg, "R10", "bg_index", int'(bg_index), bg);
    chk(int'(grid_index) == gr, "R10", "grid_index", int'(grid_index), gr);
  endtask

  task automatic do_read(input int a);
    int c = cyc;
    int exp;
    string rq;
    reg_addr = 3'(a);
    reg_rd = 1'b1;
    case (a)
      0: begin exp = ctrl_m; rq = "R7"; end
      1: begin
           exp = ((e_ly(c) >= VIS) ? 8 : 0) | (snap_m << 1) | (e_vis(c) ? 1 : 0);
           rq = "R8";
         end
      2: begin exp = (coll_frame == c / FRM) ? coll_m : 0; rq = "R9"; end
      3: begin exp = color_m; rq = "R7"; end
      4: begin exp = ((ctrl_m >> 1) & 1) ? line_snap_m : (e_ly(c) & 255); rq = "R6"; end
      5: begin exp = ((ctrl_m >> 1) & 1) ? hpos_snap_m : e_hpos(c); rq = "R6"; end
      default: begin exp = 0; rq = "R7"; end
    endcase
    if (a == 0 && e_ly(c) == VIS) ack_frame = c / FRM;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(int'(reg_rdata) == exp, rq, $sformatf("read addr %0d", a), int'(reg_rdata), exp);
  endtask

  task automatic do_write(input int a, input int d);
    int c = cyc;
    reg_addr = 3'(a);
    reg_wdata = 8'(d);
    reg_wr = 1'b1;
    case (a)
      0: begin
           ctrl_m = d;
           if ((d >> 1) & 1) begin
             line_snap_m = e_ly(c) & 255;
             hpos_snap_m = e_hpos(c);
             snap_m = 0;
           end else snap_m = 1;
         end
      2: begin coll_m = d; coll_frame = c / FRM; end
      3: color_m = d;
      default: ;
    endcase
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic random_until(input int c);
    while (cyc < c) begin
      repeat ($urandom_range(0, 400)) @(negedge clk);
      if ($urandom_range(0, 1) == 1) do_read($urandom_range(0, 7));
      else do_write($urandom_range(0, 7), $urandom_range(0, 255));
      check_outputs();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    repeat (90000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(hblank && test_pin, "R11", "hblank/test_pin in reset", int'(hblank), 1);
    chk(!vblank && !frame_irq, "R11", "vblank/irq in reset", int'(vblank | frame_irq), 0);
    chk(reg_rdata == 8'd0, "R11", "rdata in reset", int'(reg_rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs();
    // R1: live position right after reset
    do_read(5);
    do_read(4);
    // R5/R6: freeze and live reads, R10 bright bits
    do_write(3, 8'hEA);
    wait_until(10 * DOTS + 100);
    check_outputs();
    do_write(0, 8'h02);
    wait_until(20 * DOTS + 5);
    do_read(4);
    do_read(5);
    do_read(1);
    do_write(0, 8'h00);
    do_read(4);
    do_read(1);
    // R8: status write ignored
    do_write(1, 8'hFF);
    do_read(1);
    random_until(VIS * DOTS - 600);
    // R4: read on the edge entering line 240 -> raise wins
    wait_until(VIS * DOTS - 1);
    do_read(0);
    check_outputs();
    wait_until(VIS * DOTS + 20);
    do_read(0);
    check_outputs();
    // R9: write on wrap edge loses to the clear
    wait_until(FRM - 1);
    do_write(2, 8'h5A);
    check_outputs();
    do_read(2);
    do_read(1);
    do_read(4);
    random_until(FRM + VIS * DOTS - 600);
    // R3: irq held through line 240, dropped at 241 without ack
    wait_until(FRM + VIS * DOTS + 10);
    check_outputs();
    wait_until(FRM + (VIS + 1) * DOTS);
    check_outputs();
    random_until(2 * FRM + 25000);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule